// File: doc/BRIEF.md
# Functional Unit Scoreboard

This block is the central hazard bookkeeper for a core that issues instructions in program order but lets them finish out of order. The core has a small pool of functional units. Each unit belongs to a class, and the default pool holds two arithmetic units, one load unit and one store unit. The scoreboard gives each instruction three permissions in turn:

- **Issue** takes a unit.
- **Operand read** fetches the sources.
- **Result write** retires the destination.

The scoreboard grants a permission only when no structural, output (WAW), true (RAW) or anti (WAR) dependency stands in the way.

Per unit, it keeps:
- a busy flag;
- the destination and both source register numbers;
- a producer tag and a ready flag for each source.

Per register, it keeps the tag of the unit that will write it. Tag 0 means no unit and unit `u` is tag `u+1`. Data never passes through the block. The execution units sit outside it. Each unit raises its read request when it wants its operands and its write request when its result is done.

Top module: `fu_scoreboard`

## Requirements
- R1: After reset every unit is free, so no read or write grant is given even when every request is raised.
- R2: An issue request is granted to the lowest-index free unit whose class matches `iss_cls`, and `iss_unit` names that unit. The class codes are: 0 for arithmetic (units 0 and 1), 1 for load (unit 2), 2 for store (unit 3), and 3 for no unit. The request is refused when no unit of that class is free.
- R3: An issue request is refused while a busy unit is still due to write the requested destination.
- R4: A read request is granted in the same cycle only if neither source has a pending producer.
- R5: When a producer's write is granted, a consumer waiting on it may read in the next cycle. This also holds when that consumer is issued in the same cycle as the producer's write grant.
- R6: Each instruction's read is granted only once, and its write is never granted before its read.
- R7: A write is refused while another busy unit holds a source equal to the destination that it has not yet read. The write is granted in the cycle after that read.
- R8: At most one write is granted per cycle, and the lowest index wins. The write frees the unit and clears the destination's owner, so the next cycle can issue to that unit or to that destination.
- R9: Register 0 never creates a RAW, WAR or WAW dependency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_req | input | 1 | Issue request for the next instruction in order |
| iss_cls | input | CLSW | Unit class the instruction needs |
| iss_dst | input | log2(NREG) | Destination register |
| iss_src1 | input | log2(NREG) | First source register |
| iss_src2 | input | log2(NREG) | Second source register |
| iss_gnt | output | 1 | Issue granted this cycle |
| iss_unit | output | log2(NFU) | Unit chosen for the issue |
| rd_req | input | NFU | Operand read request, one bit per unit |
| rd_gnt | output | NFU | Operand read grant, one bit per unit |
| wb_req | input | NFU | Result write request, one bit per unit |
| wb_gnt | output | NFU | Result write grant, one bit per unit |

## Verification
All grants are combinational from the registered tables, so a corrupted tag or ready flag shows at the grant ports in the very next cycle that requests that entry. A stale register owner shows as a refused issue to that destination. A missed ready update shows as a consumer's read that never comes. A wrong unread-source flag shows as a write released early or held forever. The sweep pairs every producer destination with every consumer source over a small register range, so each of these faults changes a grant within a few cycles of its cause.

// File: rtl/fu_scoreboard.sv
module fu_scoreboard #(
  parameter int NFU = 4,
  parameter int NREG = 8,
  parameter int CLSW = 2,
  parameter logic [NFU*CLSW-1:0] UNIT_CLS = 8'b10_01_00_00
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     iss_req,
  input  logic [CLSW-1:0]          iss_cls,
  input  logic [$clog2(NREG)-1:0]  iss_dst,
  input  logic [$clog2(NREG)-1:0]  iss_src1,
  input  logic [$clog2(NREG)-1:0]  iss_src2,
  output logic                     iss_gnt,
  output logic [$clog2(NFU)-1:0]   iss_unit,
  input  logic [NFU-1:0]           rd_req,
  output logic [NFU-1:0]           rd_gnt,
  input  logic [NFU-1:0]           wb_req,
  output logic [NFU-1:0]           wb_gnt
);
  localparam int RW = $clog2(NREG);
  localparam int TW = $clog2(NFU + 1);
  localparam int UW = $clog2(NFU);

  logic [NFU-1:0] busy, rdd, rj, rk;
  logic [RW-1:0]  fi [NFU];
  logic [RW-1:0]  fj [NFU];
  logic [RW-1:0]  fk [NFU];
  logic [TW-1:0]  qj [NFU];
  logic [TW-1:0]  qk [NFU];
  logic [TW-1:0]  owner [NREG];

  logic [NFU-1:0] cand, war, wb_ok;
  logic [UW-1:0]  pick;
  logic           any_free, waw, wb_any;
  logic [TW-1:0]  wb_tag, p1, p2;

  for (genvar g = 0; g < NFU; g++) begin : g_cls
    assign cand[g] = !busy[g] && (UNIT_CLS[g*CLSW +: CLSW] == iss_cls);
  end

  always_comb begin
    pick = '0;
    any_free = 1'b0;
    for (int u = NFU - 1; u >= 0; u--)
      if (cand[u]) begin
        pick = UW'(u);
        any_free = 1'b1;
      end
  end

  assign waw      = (iss_dst != '0) && (owner[iss_dst] != '0);
  assign iss_gnt  = iss_req && any_free && !waw;
  assign iss_unit = pick;

  assign rd_gnt = busy & rd_req & ~rdd & rj & rk;

  always_comb begin
    war = '0;
    for (int u = 0; u < NFU; u++)
      for (int f = 0; f < NFU; f++)
        if (f != u && fi[u] != '0 && busy[f] &&
            ((fj[f] == fi[u] && rj[f]) || (fk[f] == fi[u] && rk[f])))
          war[u] = 1'b1;
  end

  assign wb_ok  = busy & rdd & wb_req & ~war;
  assign wb_any = |wb_ok;

  always_comb begin
    wb_gnt = '0;
    wb_tag = '0;
    for (int u = NFU - 1; u >= 0; u--)
      if (wb_ok[u]) begin
        wb_gnt = '0;
        wb_gnt[u] = 1'b1;
        wb_tag = TW'(u + 1);
      end
  end

  assign p1 = (iss_src1 == '0 || (wb_any && owner[iss_src1] == wb_tag)) ? '0 : owner[iss_src1];
  assign p2 = (iss_src2 == '0 || (wb_any && owner[iss_src2] == wb_tag)) ? '0 : owner[iss_src2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= '0;
      rdd  <= '0;
      rj   <= '0;
      rk   <= '0;
      for (int u = 0; u < NFU; u++) begin
        fi[u] <= '0;
        fj[u] <= '0;
        fk[u] <= '0;
        qj[u] <= '0;
        qk[u] <= '0;
      end
      for (int r = 0; r < NREG; r++) owner[r] <= '0;
    end else begin
      for (int u = 0; u < NFU; u++) begin
        if (wb_gnt[u]) begin
          busy[u] <= 1'b0;
          rdd[u]  <= 1'b0;
          rj[u]   <= 1'b0;
          rk[u]   <= 1'b0;
          qj[u]   <= '0;
          qk[u]   <= '0;
        end else if (iss_gnt && pick == UW'(u)) begin
          busy[u] <= 1'b1;
          rdd[u]  <= 1'b0;
          fi[u]   <= iss_dst;
          fj[u]   <= iss_src1;
          fk[u]   <= iss_src2;
          qj[u]   <= p1;
          qk[u]   <= p2;
          rj[u]   <= (p1 == '0);
          rk[u]   <= (p2 == '0);
        end else if (rd_gnt[u]) begin
          rdd[u] <= 1'b1;
          rj[u]  <= 1'b0;
          rk[u]  <= 1'b0;
        end else if (busy[u] && wb_any) begin
          if (qj[u] == wb_tag) begin
            qj[u] <= '0;
            rj[u] <= 1'b1;
          end
          if (qk[u] == wb_tag) begin
            qk[u] <= '0;
            rk[u] <= 1'b1;
          end
        end
      end
      for (int r = 1; r < NREG; r++) begin
        if (iss_gnt && iss_dst == RW'(r))
          owner[r] <= TW'(pick) + TW'(1);
        else if (wb_any && owner[r] == wb_tag)
          owner[r] <= '0;
      end
    end
  end

  p_owner_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_gnt && iss_dst != '0) |=> (owner[$past(iss_dst)] == TW'($past(iss_unit)) + TW'(1)));

  p_one_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wb_gnt));

  p_reg0_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
    owner[0] == '0);

  for (genvar g = 0; g < NFU; g++) begin : g_chk
    p_read_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_gnt[g] |=> !rd_gnt[g]);
    p_write_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wb_gnt[g] |=> !busy[g]);
    p_no_issue_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy[g] && iss_gnt) |-> (iss_unit != UW'(g)));
  end
endmodule

// File: tb/sim_fu_scoreboard.sv
`timescale 1ns/1ps
module sim_fu_scoreboard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       iss_req = 1'b0;
  logic [1:0] iss_cls = '0;
  logic [2:0] iss_dst = '0, iss_src1 = '0, iss_src2 = '0;
  logic       iss_gnt;
  logic [1:0] iss_unit;
  logic [3:0] rd_req = '0, rd_gnt, wb_req = '0, wb_gnt;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  fu_scoreboard u0 (
    .clk(clk), .rst_n(rst_n), .iss_req(iss_req), .iss_cls(iss_cls),
    .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
    .iss_gnt(iss_gnt), .iss_unit(iss_unit), .rd_req(rd_req),
    .rd_gnt(rd_gnt), .wb_req(wb_req), .wb_gnt(wb_gnt)
  );

  task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic nxt;
    @(negedge clk);
    iss_req = 1'b0;
    rd_req = '0;
    wb_req = '0;
  endtask

  task automatic iss(input logic [1:0] c, input logic [2:0] d, input logic [2:0] s1, input logic [2:0] s2);
    iss_req = 1'b1;
    iss_cls = c;
    iss_dst = d;
    iss_src1 = s1;
    iss_src2 = s2;
  endtask

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    nxt;
    rd_req = 4'hF; wb_req = 4'hF; #1;
    chk(rd_gnt, 4'h0, "R1 read grant after reset");
    chk(wb_gnt, 4'h0, "R1 write grant after reset");

    // structural hazards and write priority
    nxt; iss(2'd0, 3'd1, 3'd0, 3'd0); #1;
    chk({1'b0, iss_gnt, iss_unit}, 4'b0100, "R2 first arith to unit 0");
    nxt; iss(2'd0, 3'd2, 3'd0, 3'd0); #1;
    chk({1'b0, iss_gnt, iss_unit}, 4'b0101, "R2 second arith to unit 1");
    nxt; iss(2'd0, 3'd3, 3'd0, 3'd0); #1;
    chk({3'b0, iss_gnt}, 4'b0000, "R2 arith refused when both busy");
    nxt; iss(2'd3, 3'd3, 3'd0, 3'd0); #1;
    chk({3'b0, iss_gnt}, 4'b0000, "R2 class with no unit refused");
    nxt; rd_req = 4'b0011; #1;
    chk(rd_gnt, 4'b0011, "R4 reads with no producers");
    nxt; wb_req = 4'b0011; #1;
    chk(wb_gnt, 4'b0001, "R8 lower index wins write");
    nxt; wb_req = 4'b0010; iss(2'd0, 3'd3, 3'd0, 3'd0); #1;
    chk(wb_gnt, 4'b0010, "R8 loser writes next cycle");
    chk({1'b0, iss_gnt, iss_unit}, 4'b0100, "R8 freed unit reissued");
    nxt; rd_req = 4'b0001; #1;
    chk(rd_gnt, 4'b0001, "R4 read unit 0");
    nxt; wb_req = 4'b0001; #1;
    chk(wb_gnt, 4'b0001, "R8 drain unit 0");

    // anti dependency
    nxt; iss(2'd1, 3'd6, 3'd3, 3'd0); #1;
    chk({1'b0, iss_gnt, iss_unit}, 4'b0110, "R2 load to unit 2");
    nxt; iss(2'd0, 3'd3, 3'd0, 3'd0); #1;
    chk({1'b0, iss_gnt, iss_unit}, 4'b0100, "R3 no output conflict on r3");
    nxt; rd_req = 4'b0001; #1;
    chk(rd_gnt, 4'b0001, "R4 writer reads");
    nxt; wb_req = 4'b0001; #1;
    chk(wb_gnt, 4'b0000, "R7 write held by unread source");
    nxt; wb_req = 4'b0001; rd_req = 4'b0100; #1;
    chk(wb_gnt, 4'b0000, "R7 write held during reader grant");
    chk(rd_gnt, 4'b0100, "R7 reader granted");
    nxt; wb_req = 4'b0001; #1;
    chk(wb_gnt, 4'b0001, "R7 write released after read");
    nxt; wb_req = 4'b0100; #1;
    chk(wb_gnt, 4'b0100, "R7 reader writes");

    // same-cycle producer write and consumer issue
    nxt; iss(2'd0, 3'd4, 3'd0, 3'd0); #1;
    chk({1'b0, iss_gnt, iss_unit}, 4'b0100, "R5 producer issue");
    nxt; rd_req = 4'b0001; #1;
    chk(rd_gnt, 4'b0001, "R5 producer read");
    nxt; wb_req = 4'b0001; iss(2'd1, 3'd6, 3'd4, 3'd0); #1;
    chk(wb_gnt, 4'b0001, "R5 producer write");
    chk({1'b0, iss_gnt, iss_unit}, 4'b0110, "R5 consumer issue same cycle");
    nxt; rd_req = 4'b0100; iss(2'd0, 3'd4, 3'd0, 3'd0); #1;
    chk(rd_gnt, 4'b0100, "R5 consumer ready from bypass");
    chk({1'b0, iss_gnt, iss_unit}, 4'b0100, "R8 destination free after write");
    nxt; rd_req = 4'b0001; wb_req = 4'b0100; #1;
    chk(rd_gnt, 4'b0001, "R4 drain read");
    chk(wb_gnt, 4'b0100, "R6 consumer write after read");
    nxt; wb_req = 4'b0001; #1;
    chk(wb_gnt, 4'b0001, "R8 drain write");

    // sweep of producer destination against consumer source
    for (int a = 0; a < 4; a++) begin
      for (int s = 0; s < 4; s++) begin
        logic raw, wok;
        raw = (s != 0) && (s == a);
        wok = (a == 0);
        nxt; iss(2'd0, 3'(a), 3'd0, 3'd0); #1;
        chk({1'b0, iss_gnt, iss_unit}, 4'b0100, "R2 sweep producer issue");
        nxt; iss(2'd1, 3'd5, 3'(s), 3'd0); #1;
        chk({1'b0, iss_gnt, iss_unit}, 4'b0110, "R2 sweep consumer issue");
        nxt; iss(2'd0, 3'(a), 3'd0, 3'd0); rd_req = 4'b0101; #1;
        chk({3'b0, iss_gnt}, {3'b0, wok}, "R3 R9 sweep second writer");
        chk(rd_gnt, {1'b0, !raw, 2'b01}, "R4 R9 sweep consumer read");
        nxt; wb_req = 4'b0001; rd_req = wok ? 4'b0110 : 4'b0100; #1;
        chk(wb_gnt, 4'b0001, "R8 sweep producer write");
        chk(rd_gnt, {2'b00, wok, 1'b0}, "R6 sweep read not repeated");
        nxt; rd_req = 4'b0100; wb_req = wok ? 4'b0110 : 4'b0100; #1;
        chk(rd_gnt, {1'b0, raw, 2'b00}, "R5 sweep waiting read released");
        chk(wb_gnt, wok ? 4'b0010 : (raw ? 4'b0000 : 4'b0100), "R6 R8 sweep write order");
        nxt; wb_req = 4'b0100; #1;
        chk(wb_gnt, (raw || wok) ? 4'b0100 : 4'b0000, "R6 sweep final write");
      end
    end

    nxt;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule